// File: doc/BRIEF.md
# Dual-Channel Interrupt Cause Controller

This block gathers event pulses from two engine channels into one shared 32-bit cause register and turns them into one interrupt line per channel. Each channel owns one 16-bit half of the cause register and the matching half of a 32-bit mask register. A cause bit is set by an event pulse and stays set until software clears it. An interrupt line is high while any cause bit in its half is set and enabled by the mask.

Software reaches the block through a small register port with two locations. Selector 0 is the cause register and selector 1 is the mask register. Cause writes clear the bits written as zero and leave the bits written as one untouched. Each channel's driver can therefore clear its own bits without a read first and without disturbing the other channel. Mask writes store the full 32-bit value, so software updates one channel's half by reading the register, changing its half and writing the result back.

Top module: `irqc_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every cause bit, every mask bit and both interrupt lines are zero after that edge.
- R2: An event pulse on `evt_pulse[16n+k]` sets cause bit 16n+k at the same clock edge. Within each half, bit 0 is end of descriptor, bit 1 is end of chain, bit 2 is channel stopped, bit 3 is address decode error, and bits 4 to 15 are further error sources.
- R3: A write to the cause register (`reg_sel`=0) clears every cause bit whose write-data bit is 0. Cause bits whose write-data bit is 1 keep their value.
- R4: A cause write of ones in one 16-bit half and zeros in the other clears only the zeroed channel's cause bits. The other channel's bits are unchanged.
- R5: A write to the mask register (`reg_sel`=1) loads all 32 bits from `reg_wdata`. Without such a write, the mask holds its value.
- R6: `irq_line[n]` is 1 exactly when some bit of half n is set in both the cause register and the mask register. A masked cause bit stays readable in the cause register.
- R7: When an event pulse and a clearing cause write hit the same bit in the same cycle, the bit ends up set.
- R8: Cause bits are sticky. With no events and no cause writes, the cause register keeps its value. A cause bit rises only on an event pulse for that bit.
- R9: `reg_rdata` combinationally returns the cause register when `reg_sel` is 0 and the mask register when `reg_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 cause, 1 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 32 | Event pulses, bits [16n+15:16n] belong to channel n |
| irq_line | output | 2 | Interrupt line per channel |

## Verification
The assertions assume that reset is held high through the first clock edge. They also assume that every input is known and synchronous to `clk`, so that the sampled write data and event pulses of one cycle fully determine the next register state. The stimulus meets this by holding reset for several cycles, driving every input only on the falling edge and returning the strobe and event pulses to zero after each step. The stimulus includes cycles where an event and a clearing write target the same bit. Under these assumptions, that overlap is a legal input and the event-wins rule must hold there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Default geometry: channels and cause bits per channel
    localparam int unsigned NUM_CH_DEF = 2;
    localparam int unsigned CH_W_DEF   = 16;

    // Register selector of the access port
    typedef enum logic {
        SEL_CAUSE = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

    // Next cause value of one half: a write keeps only bits written as one,
    // then events are ORed in so that a same-cycle event always wins.
    function automatic logic [CH_W_DEF-1:0] cause_update(
        input logic [CH_W_DEF-1:0] cur,
        input logic                wr,
        input logic [CH_W_DEF-1:0] keep,
        input logic [CH_W_DEF-1:0] evt
    );
        logic [CH_W_DEF-1:0] base;
        base = wr ? (cur & keep) : cur;
        return base | evt;
    endfunction

endpackage

// File: rtl/irqc_cause_bank.sv
module irqc_cause_bank
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CH_W_DEF-1:0] wr_keep,
    input  logic [CH_W_DEF-1:0] evt,
    output logic [CH_W_DEF-1:0] cause_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_update(cause_q, wr_en, wr_keep, evt);
        end
    end

endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end

endmodule

// File: rtl/irqc_line_gen.sv
module irqc_line_gen #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cause,
    input  logic [W-1:0] mask,
    output logic         line
);

    logic [W-1:0] pend;

    always_comb begin
        pend = cause & mask;
        line = |pend;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_CH = NUM_CH_DEF,
    parameter int unsigned CH_W   = CH_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic                     reg_sel,
    input  logic [NUM_CH*CH_W-1:0]   reg_wdata,
    output logic [NUM_CH*CH_W-1:0]   reg_rdata,
    input  logic [NUM_CH*CH_W-1:0]   evt_pulse,
    output logic [NUM_CH-1:0]        irq_line
);

    localparam int unsigned REG_W = NUM_CH * CH_W;

    reg_sel_e         sel;
    logic             wr_cause;
    logic             wr_mask;
    logic [REG_W-1:0] cause_all;
    logic [REG_W-1:0] mask_all;

    always_comb begin
        sel      = reg_sel_e'(reg_sel);
        wr_cause = reg_we && (sel == SEL_CAUSE);
        wr_mask  = reg_we && (sel == SEL_MASK);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int unsigned LO = ch * CH_W;

        irqc_cause_bank u_cause (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_cause),
            .wr_keep (reg_wdata[LO +: CH_W]),
            .evt     (evt_pulse[LO +: CH_W]),
            .cause_q (cause_all[LO +: CH_W])
        );

        irqc_mask_bank #(.W(CH_W)) u_mask (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_mask),
            .wr_data (reg_wdata[LO +: CH_W]),
            .mask_q  (mask_all[LO +: CH_W])
        );

        irqc_line_gen #(.W(CH_W)) u_line (
            .cause (cause_all[LO +: CH_W]),
            .mask  (mask_all[LO +: CH_W]),
            .line  (irq_line[ch])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_CAUSE: reg_rdata = cause_all;
            SEL_MASK:  reg_rdata = mask_all;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CH_W   = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   reg_we,
    input logic                   reg_sel,
    input logic [NUM_CH*CH_W-1:0] reg_wdata,
    input logic [NUM_CH*CH_W-1:0] evt_pulse,
    input logic [NUM_CH*CH_W-1:0] cause_all,
    input logic [NUM_CH*CH_W-1:0] mask_all,
    input logic [NUM_CH-1:0]      irq_line
);

    localparam int unsigned REG_W = NUM_CH * CH_W;

    logic [REG_W-1:0] clr_req;
    always_comb clr_req = (reg_we && !reg_sel) ? ~reg_wdata : '0;

    // R1: reset clears cause and mask
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (cause_all == '0 && mask_all == '0));

    // R2: every pulsed bit is set at the next sample
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_pulse) |=> ((cause_all & $past(evt_pulse)) == $past(evt_pulse)));

    // R3 / R7: a bit written as zero ends clear unless its event fired
    assert_zero_write_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel) |=>
            ((cause_all & ~$past(reg_wdata) & ~$past(evt_pulse)) == '0));

    // R8: bits not cleared never fall
    assert_no_spurious_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we || !reg_we) |=> (($past(cause_all) & ~$past(clr_req) & ~cause_all) == '0));

    // R8: bits rise only on an event
    assert_rise_needs_evt_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we || !reg_we) |=> ((cause_all & ~$past(cause_all) & ~$past(evt_pulse)) == '0));

    // R5: a mask write loads the data, otherwise the mask holds
    assert_mask_load_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel) |=> (mask_all == $past(reg_wdata)));
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_sel) |=> $stable(mask_all));

    // R6: each line follows its enabled causes
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_line
        assert_line_R6: assert property (@(posedge clk) disable iff (rst)
            irq_line[ch] == (|(cause_all[ch*CH_W +: CH_W] & mask_all[ch*CH_W +: CH_W])));
    end

endmodule

bind irqc_top irqc_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .evt_pulse (evt_pulse),
    .cause_all (cause_all),
    .mask_all  (mask_all),
    .irq_line  (irq_line)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    typedef struct packed {
        logic        we;
        logic        sel;
        logic [31:0] wdata;
        logic [31:0] evt;
        logic [31:0] exp_cause;
        logic [31:0] exp_mask;
        logic [1:0]  exp_irq;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b1, 32'h0000_0001, 32'h0, 32'h0000_0000, 32'h0000_0001, 2'b00}, // R5
        '{1'b0, 1'b0, 32'h0,         32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 2'b01}, // R2 R6
        '{1'b0, 1'b0, 32'h0,         32'h0002_0000, 32'h0002_0001, 32'h0000_0001, 2'b01}, // R2 R6 masked
        '{1'b1, 1'b1, 32'h0002_0001, 32'h0, 32'h0002_0001, 32'h0002_0001, 2'b11}, // R5 R6
        '{1'b1, 1'b0, 32'hFFFF_0000, 32'h0, 32'h0002_0000, 32'h0002_0001, 2'b10}, // R4
        '{1'b0, 1'b0, 32'h0,         32'h0000_0008, 32'h0002_0008, 32'h0002_0001, 2'b10}, // R2 R6
        '{1'b1, 1'b0, 32'hFFFF_FFF7, 32'h0000_0008, 32'h0002_0008, 32'h0002_0001, 2'b10}, // R7
        '{1'b1, 1'b0, 32'hFFFD_FFFF, 32'h0, 32'h0000_0008, 32'h0002_0001, 2'b00}, // R3
        '{1'b0, 1'b0, 32'h0,         32'hFFF0_0010, 32'hFFF0_0018, 32'h0002_0001, 2'b00}, // R2 R6
        '{1'b1, 1'b1, 32'h0010_0000, 32'h0, 32'hFFF0_0018, 32'h0010_0000, 2'b10}, // R5 R6
        '{1'b1, 1'b0, 32'h0000_FFFF, 32'h0, 32'h0000_0018, 32'h0010_0000, 2'b00}, // R4
        '{1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0018, 32'h0010_0000, 2'b00}, // R3
        '{1'b0, 1'b0, 32'h0,         32'h0, 32'h0000_0018, 32'h0010_0000, 2'b00}  // R8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_pulse = '0;
    logic [1:0]  irq_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq_line  (irq_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R9: both registers are read through the selector
    task automatic read_all(output logic [31:0] c, output logic [31:0] m, output logic [1:0] i);
        reg_sel = 1'b0;
        #0.5;
        c = reg_rdata;
        reg_sel = 1'b1;
        #0.5;
        m = reg_rdata;
        i = irq_line;
    endtask

    task automatic step(input logic we, input logic sel, input logic [31:0] wd, input logic [31:0] ev);
        @(negedge clk);
        reg_we    = we;
        reg_sel   = sel;
        reg_wdata = wd;
        evt_pulse = ev;
        @(posedge clk);
        #1;
        reg_we    = 1'b0;
        evt_pulse = '0;
    endtask

    initial begin
        logic [31:0] c, m;
        logic [1:0]  i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_all(c, m, i);
        check("R1 cause after reset", c, 32'h0);
        check("R1 mask after reset", m, 32'h0);
        check("R1 irq after reset", {30'h0, i}, 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            step(TBL[k].we, TBL[k].sel, TBL[k].wdata, TBL[k].evt);
            read_all(c, m, i);
            check("R2/R3/R4/R7/R8 cause (R9 sel0)", c, TBL[k].exp_cause);
            check("R5 mask (R9 sel1)", m, TBL[k].exp_mask);
            check("R6 irq", {30'h0, i}, {30'h0, TBL[k].exp_irq});
        end

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        read_all(c, m, i);
        check("R1 cause after mid reset", c, 32'h0);
        check("R1 mask after mid reset", m, 32'h0);
        check("R1 irq after mid reset", {30'h0, i}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R7 with R4: clear ch0 half while ch0 and ch1 events arrive
        step(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0);
        step(1'b1, 1'b0, 32'hFFFF_0000, 32'h0001_0001);
        read_all(c, m, i);
        check("R7 event beats clear", c, 32'h0001_0001);
        check("R6 both lines", {30'h0, i}, 32'h3);

        // R4: clear ch1 only, ch0 line stays
        step(1'b1, 1'b0, 32'h0000_FFFF, 32'h0);
        read_all(c, m, i);
        check("R4 clear ch1 only", c, 32'h0000_0001);
        check("R6 ch0 line only", {30'h0, i}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule